// File: doc/BRIEF.md
# Serial Signature Compactor

This block folds the serial response stream of one observed output into a 16-bit signature. The folding is done by a linear feedback shift register, and each strobe absorbs one response bit. A test starts with a clear, which empties the register. One strobe is then given per applied test pattern.

When the test sequence is over, an end-of-test pulse freezes the register. The pulse also compares the register with a supplied known-good signature. The block then raises a done flag and a match flag that gives the go/no-go verdict. Both flags hold until the next clear.

Any stream of exactly the register width maps to a signature of its own. Longer streams share signatures evenly, so a faulty long stream slips through with a probability near 2^-16. The register width and the feedback taps are parameters. The default is x^16 + x^12 + x^9 + x^7 + 1.

Top module: `sig_compactor`

## Requirements
- R1: While reset is held, and right after it is released, the signature reads all zeros and both done and match are low.
- R2: A clear sets the signature to zero and drops done and match one clock later. It wins over strobe and end-of-test in the same cycle.
- R3: A strobe while not done and without end-of-test makes the next signature equal to {sig[W-2:0], fb}. Here fb is the data bit XOR the stages selected by the tap mask. For the default width, those stages are bits 15, 11, 8 and 6 (x^16+x^12+x^9+x^7+1). Bits are applied first-to-last.
- R4: Without a strobe, the data input has no effect and the signature keeps its value.
- R5: Starting from a clear, every stream of exactly W bits gives a different signature.
- R6: Starting from a clear, streams of W+1 bits are spread evenly, with exactly two streams per signature.
- R7: End-of-test while not done raises done on the next clock. In the same update, match is set to 1 exactly when the signature equals the golden input in the end-of-test cycle.
- R8: While done is high and there is no clear, strobes and further end-of-test pulses are ignored. The signature and match stay frozen, even if the golden input changes.
- R9: A strobe in the same cycle as end-of-test is not absorbed. The compared and frozen signature excludes that bit.
- R10: Match is never high while done is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| clear_i | input | 1 | Start of test: zero the signature and drop the flags |
| strobe_i | input | 1 | Absorb `data_i` into the signature this cycle |
| data_i | input | 1 | Serial response bit from the observed output |
| eot_i | input | 1 | End of test: freeze and compare |
| golden_i | input | WIDTH | Known-good signature |
| sig_o | output | WIDTH | Current signature |
| done_o | output | 1 | Test closed; held until clear |
| match_o | output | 1 | Signature equalled the golden value at close |

## Verification
A narrow 4-bit instance with taps x^4+x^3+1 is swept over every 4-bit and every 5-bit stream. This shows that full-width streams are separated one-to-one and that one extra bit pairs streams exactly two per signature.

The 16-bit instance gets several kinds of stream:
- a single one in each of 16 positions, which separates each tap and stage;
- all-ones and alternating streams;
- a long pseudo-random stream, which follows the feedback over hundreds of steps.

End-of-test is tried with a correct and a wrong golden value, with a simultaneous strobe, and with strobes, golden changes and clears after done. These cases tell the frozen verdict apart from a live comparison.

// File: rtl/sig_pkg.sv
package sig_pkg;

  // Operation selected for the current cycle
  typedef enum logic [1:0] {
    SIG_HOLD  = 2'd0,
    SIG_WIPE  = 2'd1,
    SIG_SHIFT = 2'd2,
    SIG_CLOSE = 2'd3
  } sig_op_e;

  localparam int unsigned SIG_W_DEF    = 16;
  // stages 15, 11, 8, 6 feed back: x^16 + x^12 + x^9 + x^7 + 1
  localparam logic [15:0] SIG_TAPS_DEF = 16'h8940;

endpackage

// File: rtl/sig_rst_sync.sv
module sig_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_sync_n = pipe_q[STAGES-1];

endmodule

// File: rtl/sig_ctrl.sv
module sig_ctrl
  import sig_pkg::*;
(
  input  logic    clear_i,
  input  logic    strobe_i,
  input  logic    eot_i,
  input  logic    done_i,
  output sig_op_e op_o
);

  // Priority: clear, then frozen-after-done, then close, then shift
  always_comb begin
    if (clear_i)       op_o = SIG_WIPE;
    else if (done_i)   op_o = SIG_HOLD;
    else if (eot_i)    op_o = SIG_CLOSE;
    else if (strobe_i) op_o = SIG_SHIFT;
    else               op_o = SIG_HOLD;
  end

endmodule

// File: rtl/sig_lfsr.sv
module sig_lfsr
  import sig_pkg::*;
#(
  parameter int unsigned     WIDTH    = SIG_W_DEF,
  parameter logic [WIDTH-1:0] TAP_MASK = WIDTH'(SIG_TAPS_DEF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sig_op_e          op_i,
  input  logic             din_i,
  output logic [WIDTH-1:0] state_o
);

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic [WIDTH-1:0] tap_terms;
  logic             fb;
  logic             en;

  // one AND term per stage, selected by the tap mask
  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_tap
    if (TAP_MASK[gi]) begin : g_on
      assign tap_terms[gi] = state_q[gi];
    end else begin : g_off
      assign tap_terms[gi] = 1'b0;
    end
  end

  always_comb begin
    fb = (^tap_terms) ^ din_i;
    en = (op_i == SIG_WIPE) || (op_i == SIG_SHIFT);
    unique case (op_i)
      SIG_WIPE:  state_d = '0;
      SIG_SHIFT: state_d = {state_q[WIDTH-2:0], fb};
      default:   state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  state_q <= '0;
    else if (en) state_q <= state_d;
  end

  assign state_o = state_q;

  // R2
  wipe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == SIG_WIPE |=> state_q == '0);

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == SIG_HOLD || op_i == SIG_CLOSE) |=> $stable(state_q));

  // R3
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == SIG_SHIFT |=> state_q[WIDTH-1:1] == $past(state_q[WIDTH-2:0]));

endmodule

// File: rtl/sig_judge.sv
module sig_judge
  import sig_pkg::*;
#(
  parameter int unsigned WIDTH = SIG_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sig_op_e          op_i,
  input  logic [WIDTH-1:0] sig_i,
  input  logic [WIDTH-1:0] golden_i,
  output logic             done_o,
  output logic             match_o
);

  logic [WIDTH-1:0] eq_bits;
  logic             hit;
  logic             done_q, done_d;
  logic             match_q, match_d;
  logic             en;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_eq
    assign eq_bits[gi] = ~(sig_i[gi] ^ golden_i[gi]);
  end

  always_comb begin
    hit     = &eq_bits;
    en      = (op_i == SIG_WIPE) || (op_i == SIG_CLOSE);
    done_d  = done_q;
    match_d = match_q;
    if (op_i == SIG_WIPE) begin
      done_d  = 1'b0;
      match_d = 1'b0;
    end else if (op_i == SIG_CLOSE) begin
      done_d  = 1'b1;
      match_d = hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      match_q <= 1'b0;
    end else if (en) begin
      done_q  <= done_d;
      match_q <= match_d;
    end
  end

  assign done_o  = done_q;
  assign match_o = match_q;

  // R10
  match_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_q |-> done_q);

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && op_i != SIG_WIPE) |=> (done_q && $stable(match_q)));

  // R7
  close_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == SIG_CLOSE |=> done_q);

endmodule

// File: rtl/sig_compactor.sv
module sig_compactor
  import sig_pkg::*;
#(
  parameter int unsigned      WIDTH    = SIG_W_DEF,
  parameter logic [WIDTH-1:0] TAP_MASK = WIDTH'(SIG_TAPS_DEF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             strobe_i,
  input  logic             data_i,
  input  logic             eot_i,
  input  logic [WIDTH-1:0] golden_i,
  output logic [WIDTH-1:0] sig_o,
  output logic             done_o,
  output logic             match_o
);

  logic    rst_sync_n;
  sig_op_e op;

  sig_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sig_ctrl i_ctrl (
    .clear_i  (clear_i),
    .strobe_i (strobe_i),
    .eot_i    (eot_i),
    .done_i   (done_o),
    .op_o     (op)
  );

  sig_lfsr #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) i_lfsr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .op_i    (op),
    .din_i   (data_i),
    .state_o (sig_o)
  );

  sig_judge #(.WIDTH(WIDTH)) i_judge (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .op_i     (op),
    .sig_i    (sig_o),
    .golden_i (golden_i),
    .done_o   (done_o),
    .match_o  (match_o)
  );

  // R9
  eot_freeze_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (strobe_i && eot_i && !clear_i && !done_o) |=> $stable(sig_o));

endmodule

// File: tb/test_sig_compactor.sv
`timescale 1ns/1ps
module test_sig_compactor;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clear, strobe, data, eot;
  logic [15:0] golden;
  logic [15:0] sig;
  logic        done, match;
  logic [3:0]  s_sig;
  logic        s_done, s_match;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] mb, ms;

  always #2 clk = ~clk;

  sig_compactor i_sig_compactor (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .strobe_i(strobe),
    .data_i(data), .eot_i(eot), .golden_i(golden),
    .sig_o(sig), .done_o(done), .match_o(match)
  );

  sig_compactor #(.WIDTH(4), .TAP_MASK(4'hC)) i_sig_compactor_w4 (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .strobe_i(strobe),
    .data_i(data), .eot_i(eot), .golden_i(golden[3:0]),
    .sig_o(s_sig), .done_o(s_done), .match_o(s_match)
  );

  function automatic logic [15:0] mstep(input logic [15:0] s, input logic d,
                                        input int w, input logic [15:0] taps);
    logic fb;
    fb = d ^ (^(s & taps));
    s  = (s << 1) | {15'd0, fb};
    return s & (16'hFFFF >> (16 - w));
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic c, input logic st, input logic d, input logic e);
    clear = c; strobe = st; data = d; eot = e;
    @(negedge clk);
    clear = 1'b0; strobe = 1'b0; eot = 1'b0;
  endtask

  task automatic wipe();
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    mb = '0; ms = '0;
  endtask

  task automatic push(input logic d);
    tick(1'b0, 1'b1, d, 1'b0);
    mb = mstep(mb, d, 16, 16'h8940);
    ms = mstep(ms, d, 4, 16'h000C);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] rng;
    logic [15:0] uniq [16];
    int          cnt [16];
    logic [15:0] frozen;
    rst_n = 1'b0; clear = 0; strobe = 0; data = 0; eot = 0; golden = '0;
    mb = '0; ms = '0;
    repeat (3) @(negedge clk);
    chk("R1 sig in reset", sig, 16'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 sig", sig, 16'h0);
    chk("R1 done", {15'd0, done}, 16'h0);
    chk("R1 match", {15'd0, match}, 16'h0);

    // R4: data without strobe has no effect
    tick(0, 0, 1, 0); tick(0, 0, 1, 0);
    chk("R4 idle from zero", sig, 16'h0);
    push(1); push(0); push(1);
    for (int i = 0; i < 6; i++) tick(0, 0, i[0], 0);
    chk("R4 idle held", sig, mb);

    // R3: long pseudo-random stream, checked every step on both widths
    wipe();
    rng = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      rng = rng ^ (rng << 7); rng = rng ^ (rng >> 9); rng = rng ^ (rng << 8);
      push(rng[0]);
      chk("R3 step w16", sig, mb);
      chk("R3 step w4", {12'd0, s_sig}, ms);
    end
    chk("R10 match before close", {15'd0, match}, 16'h0);

    // R7: close with correct golden
    golden = mb;
    tick(0, 0, 0, 1);
    chk("R7 done", {15'd0, done}, 16'h1);
    chk("R7 match good", {15'd0, match}, 16'h1);
    frozen = mb;
    // R8: frozen after done
    for (int i = 0; i < 5; i++) tick(0, 1, 1, 0);
    chk("R8 sig frozen", sig, frozen);
    golden = ~frozen;
    tick(0, 0, 0, 0);
    chk("R8 match held on golden change", {15'd0, match}, 16'h1);
    tick(0, 1, 0, 1);
    chk("R8 second eot ignored", {15'd0, match}, 16'h1);
    chk("R8 sig after eot", sig, frozen);

    // R2: clear beats strobe and eot
    tick(1, 1, 1, 1); mb = '0; ms = '0;
    chk("R2 sig", sig, 16'h0);
    chk("R2 done", {15'd0, done}, 16'h0);
    chk("R2 match", {15'd0, match}, 16'h0);

    // R7: close with wrong golden
    for (int i = 0; i < 20; i++) push(i[1] ^ i[0]);
    chk("R10 match low before close", {15'd0, match}, 16'h0);
    golden = mb ^ 16'h0001;
    tick(0, 0, 0, 1);
    chk("R7 done bad", {15'd0, done}, 16'h1);
    chk("R7 match bad", {15'd0, match}, 16'h0);

    // R9: strobe alongside eot is not absorbed
    wipe();
    for (int i = 0; i < 5; i++) push(1);
    golden = mb;
    tick(0, 1, 1, 1);
    chk("R9 sig excludes bit", sig, mb);
    chk("R9 match", {15'd0, match}, 16'h1);

    // R5: single-one 16-bit streams on the wide instance
    for (int k = 0; k < 16; k++) begin
      wipe();
      for (int b = 0; b < 16; b++) push(b == k);
      chk("R5 impulse", sig, mb);
      uniq[k] = sig;
    end
    for (int a = 0; a < 16; a++)
      for (int b = a + 1; b < 16; b++)
        if (uniq[a] === uniq[b]) chk("R5 impulse distinct", uniq[b], ~uniq[a]);
    n_cmp++;
    wipe();
    for (int b = 0; b < 16; b++) push(1);
    chk("R5 all ones", sig, mb);
    frozen = sig;
    wipe();
    for (int b = 0; b < 16; b++) push(b[0]);
    chk("R5 alternating", sig, mb);
    if (sig === frozen) chk("R5 ones vs alternating distinct", sig, ~frozen);
    n_cmp++;

    // R5: exhaustive 4-bit streams on the narrow instance
    for (int i = 0; i < 16; i++) cnt[i] = 0;
    for (int v = 0; v < 16; v++) begin
      wipe();
      for (int b = 3; b >= 0; b--) push(v[b]);
      chk("R5 w4 model", {12'd0, s_sig}, ms);
      cnt[s_sig]++;
    end
    for (int i = 0; i < 16; i++) chk("R5 w4 one per signature", 16'(cnt[i]), 16'd1);

    // R6: exhaustive 5-bit streams, two per signature
    for (int i = 0; i < 16; i++) cnt[i] = 0;
    for (int v = 0; v < 32; v++) begin
      wipe();
      for (int b = 4; b >= 0; b--) push(v[b]);
      cnt[s_sig]++;
    end
    for (int i = 0; i < 16; i++) chk("R6 w4 two per signature", 16'(cnt[i]), 16'd2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule